// File: doc/BRIEF.md
# Serial-Line Diagnostic Counter Bank

This block keeps the statistics and the diagnostic state of a serial-line slave. It holds eight 16-bit event counters, a 16-bit diagnostic register and a listen-only flag. The frame receiver and the response logic send it one-cycle status pulses. The frame receiver reports each finished frame with an error flag and address-match flags. The response logic reports overrun, exception, negative-acknowledge and busy events. The block turns these pulses into counter increments, following rules based on how each frame ended.

The block also serves diagnostics requests. A request is a 16-bit subfunction code and a 16-bit data word. One cycle after the request, the block answers in one of three ways: a result word, an error code, or a "no reply" indication. Some subfunctions read a counter or the diagnostic register. Others clear state, restart communications or enter listen-only mode. Assembling the request from received bytes and sending the reply are handled elsewhere.

Top module: `diag_counter_bank`

## Requirements
- R1: After a synchronous active-low reset, all counters are 0, the diagnostic register is 0, `listen_only` is 0 and `rsp_valid` is 0.
- R2: When `frm_done` is high, a frame with `frm_err` low adds one to the bus-message counter (index 0). A frame with `frm_err` high adds one to the communication-error counter (index 1) only.
- R3: A frame with `frm_err` low and `frm_addr_hit` high adds one to the slave-message counter (index 3). If `frm_bcast` is also high, it adds one to the no-response counter (index 4) as well.
- R4: Each cycle with a pulse adds one to the matching counter: `exc_evt` to index 2, `nak_evt` to index 5, `busy_evt` to index 6 and `ovr_evt` to index 7. Every counter is 16 bits wide and wraps from 0xFFFF to 0.
- R5: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. `rsp_kind` is 0 for a data reply, 1 for an error reply and 2 for no reply. Subfunctions 11 to 18 with data 0 return the counter at index (subfunction − 11), taking its value from before the request's clock edge.
- R6: Subfunction 10 with data 0 clears all counters and the diagnostic register, and echoes the data word. A clear takes priority over an increment or a bit set in the same cycle.
- R7: Subfunction 20 with data 0 clears only the overrun counter (index 7) and echoes the data word.
- R8: Each bit set in `diag_set` sets the same bit of the diagnostic register, and the bit stays set until cleared. Subfunction 2 with data 0 returns the diagnostic register.
- R9: Subfunction 1 with data 0x0000 or 0xFF00 clears every counter except NAK (index 5) and busy (index 6), leaves listen-only mode and echoes the data word. With any other data word it returns error 3 and changes nothing.
- R10: Subfunction 4 with data 0 sets `listen_only` and gives the no-reply kind.
- R11: While `listen_only` is 1, every request other than subfunction 1 gives the no-reply kind and changes no state. Counters keep counting events while `listen_only` is 1.
- R12: Error code 1 is returned when the subfunction's high byte is nonzero, or when its low byte is not 0, 1, 2, 4, 10, 11–18 or 20. This check comes before the data-word check. Subfunctions 2, 4, 10, 11–18 and 20 with a nonzero data word return error 3. Subfunction 0 echoes any data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_done | input | 1 | Pulse: a frame has ended |
| frm_err | input | 1 | The ended frame had a framing, length or CRC error |
| frm_addr_hit | input | 1 | The ended frame was addressed to this slave or was a broadcast |
| frm_bcast | input | 1 | The ended frame used the broadcast address |
| ovr_evt | input | 1 | Pulse: character overrun in the UART |
| exc_evt | input | 1 | Pulse: an exception reply was sent |
| nak_evt | input | 1 | Pulse: a negative-acknowledge reply was sent |
| busy_evt | input | 1 | Pulse: a request was rejected because the slave was busy |
| diag_set | input | 16 | Bits to set in the diagnostic register |
| req_valid | input | 1 | A diagnostics request is present |
| req_sub | input | 16 | Subfunction code of the request |
| req_data | input | 16 | Data word of the request |
| rsp_valid | output | 1 | A response is present |
| rsp_kind | output | 2 | Response kind: 0 data, 1 error, 2 no reply |
| rsp_data | output | 16 | Result word (when the kind is data) |
| rsp_err | output | 8 | Error code (when the kind is error) |
| listen_only | output | 1 | Listen-only mode is active |

## Verification
A wrong counter state stays hidden until the matching subfunction 11–18 reads it. The bench therefore reads counters at random points mixed with traffic, and every data reply is compared against a model. A stuck or wrongly routed increment shows up as a wrong count on the next read of that counter. A stale clear shows up as a nonzero value right after subfunction 10, 20 or 1. A wrong listen-only state shows up on the `listen_only` port in the cycle after the request, and it also turns the next non-restart reply into the wrong kind. The wrap-around is exercised by driving the overrun counter through a full 65536-pulse cycle.

// File: rtl/diag_pkg.sv
// Package: constants shared by the diagnostic counter bank.
// Assumes counter index order matches subfunction 11..18 read order.
package diag_pkg;
    localparam int NCNT = 8;

    localparam int IX_BUS_MSG  = 0;
    localparam int IX_COMM_ERR = 1;
    localparam int IX_EXC      = 2;
    localparam int IX_SLV_MSG  = 3;
    localparam int IX_NO_RSP   = 4;
    localparam int IX_NAK      = 5;
    localparam int IX_BUSY     = 6;
    localparam int IX_OVR      = 7;

    localparam logic [7:0] SUB_ECHO    = 8'd0;
    localparam logic [7:0] SUB_RESTART = 8'd1;
    localparam logic [7:0] SUB_GETDIAG = 8'd2;
    localparam logic [7:0] SUB_LISTEN  = 8'd4;
    localparam logic [7:0] SUB_CLRALL  = 8'd10;
    localparam logic [7:0] SUB_CNT_LO  = 8'd11;
    localparam logic [7:0] SUB_CNT_HI  = 8'd18;
    localparam logic [7:0] SUB_CLROVR  = 8'd20;

    localparam logic [7:0] ERR_BAD_SUB  = 8'd1;
    localparam logic [7:0] ERR_BAD_DATA = 8'd3;

    typedef enum logic [1:0] {
        RSP_DATA = 2'd0,
        RSP_ERR  = 2'd1,
        RSP_NONE = 2'd2
    } rsp_kind_e;
endpackage

// File: rtl/diag_event_map.sv
// Module: diag_event_map
// Turns frame-outcome status and event pulses into one increment
// strobe per counter. Assumes every input is a single-cycle pulse.
module diag_event_map
    import diag_pkg::*;
(
    input  logic            frm_done,
    input  logic            frm_err,
    input  logic            frm_addr_hit,
    input  logic            frm_bcast,
    input  logic            ovr_evt,
    input  logic            exc_evt,
    input  logic            nak_evt,
    input  logic            busy_evt,
    output logic [NCNT-1:0] inc_vec
);
    logic good_frame;

    // Frame outcome and the event strobes, mapped onto counter indices.
    always_comb begin
        good_frame              = frm_done && !frm_err;
        inc_vec                 = '0;
        inc_vec[IX_BUS_MSG]     = good_frame;
        inc_vec[IX_COMM_ERR]    = frm_done && frm_err;
        inc_vec[IX_SLV_MSG]     = good_frame && frm_addr_hit;
        inc_vec[IX_NO_RSP]      = good_frame && frm_addr_hit && frm_bcast;
        inc_vec[IX_EXC]         = exc_evt;
        inc_vec[IX_NAK]         = nak_evt;
        inc_vec[IX_BUSY]        = busy_evt;
        inc_vec[IX_OVR]         = ovr_evt;
    end
endmodule

// File: rtl/diag_counter.sv
// Module: diag_counter
// One wrapping event counter. A clear takes priority over an increment.
// Assumes a synchronous active-low reset.
module diag_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] q
);
    // Count up, wrapping at 2**W; clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (clr)    q <= '0;
        else if (inc)    q <= q + 1'b1;
    end

    // R6
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (q == $past(q) + 1'b1));
endmodule

// File: rtl/diag_req_decode.sv
// Module: diag_req_decode
// Combinational decoder for diagnostics requests. It produces the
// response fields and the state-change strobes for one request.
// Assumes counter values arrive flattened, with index 0 in the low bits.
module diag_req_decode
    import diag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              req_valid,
    input  logic [15:0]       req_sub,
    input  logic [15:0]       req_data,
    input  logic              lo_mode,
    input  logic [NCNT*W-1:0] cnt_flat,
    input  logic [W-1:0]      diag_reg,
    output rsp_kind_e         kind,
    output logic [W-1:0]      rdata,
    output logic [7:0]        err,
    output logic [NCNT-1:0]   clr_vec,
    output logic              clr_diag,
    output logic              set_lo,
    output logic              clr_lo
);
    localparam int IXW = $clog2(NCNT);

    logic [7:0]     sub_lo;
    logic           sub_hi_bad;
    logic           data_zero;
    logic [IXW-1:0] cnt_ix;
    logic [7:0]     ix_wide;

    // Field split and counter index derivation.
    always_comb begin
        sub_lo     = req_sub[7:0];
        sub_hi_bad = (req_sub[15:8] != 8'd0);
        data_zero  = (req_data == 16'd0);
        ix_wide    = sub_lo - SUB_CNT_LO;
        cnt_ix     = ix_wide[IXW-1:0];
    end

    // Subfunction dispatch with listen-only gating and error precedence.
    always_comb begin
        kind     = RSP_DATA;
        rdata    = req_data;
        err      = 8'd0;
        clr_vec  = '0;
        clr_diag = 1'b0;
        set_lo   = 1'b0;
        clr_lo   = 1'b0;
        if (!req_valid) begin
            kind  = RSP_NONE;
            rdata = '0;
        end else if (lo_mode && (sub_hi_bad || sub_lo != SUB_RESTART)) begin
            kind  = RSP_NONE;
            rdata = '0;
        end else if (sub_hi_bad) begin
            kind = RSP_ERR;
            err  = ERR_BAD_SUB;
        end else begin
            unique case (sub_lo)
                SUB_ECHO: ;
                SUB_RESTART: begin
                    if (data_zero || req_data == 16'hFF00) begin
                        clr_vec           = '1;
                        clr_vec[IX_NAK]   = 1'b0;
                        clr_vec[IX_BUSY]  = 1'b0;
                        clr_lo            = 1'b1;
                    end else begin
                        kind = RSP_ERR;
                        err  = ERR_BAD_DATA;
                    end
                end
                SUB_GETDIAG: begin
                    if (data_zero) rdata = diag_reg;
                    else begin kind = RSP_ERR; err = ERR_BAD_DATA; end
                end
                SUB_LISTEN: begin
                    if (data_zero) begin
                        kind   = RSP_NONE;
                        set_lo = 1'b1;
                    end else begin
                        kind = RSP_ERR;
                        err  = ERR_BAD_DATA;
                    end
                end
                SUB_CLRALL: begin
                    if (data_zero) begin
                        clr_vec  = '1;
                        clr_diag = 1'b1;
                    end else begin
                        kind = RSP_ERR;
                        err  = ERR_BAD_DATA;
                    end
                end
                SUB_CLROVR: begin
                    if (data_zero) clr_vec[IX_OVR] = 1'b1;
                    else begin kind = RSP_ERR; err = ERR_BAD_DATA; end
                end
                default: begin
                    if (sub_lo >= SUB_CNT_LO && sub_lo <= SUB_CNT_HI) begin
                        if (data_zero) rdata = cnt_flat[cnt_ix*W +: W];
                        else begin kind = RSP_ERR; err = ERR_BAD_DATA; end
                    end else begin
                        kind = RSP_ERR;
                        err  = ERR_BAD_SUB;
                    end
                end
            endcase
            if (kind == RSP_ERR) rdata = '0;
        end
    end
endmodule

// File: rtl/diag_counter_bank.sv
// Module: diag_counter_bank (top)
// Serial-line diagnostic counters, diagnostic register and listen-only
// flag, plus a registered diagnostics request/response port.
// Assumes single-cycle status pulses and one request per cycle at most.
module diag_counter_bank
    import diag_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frm_done,
    input  logic        frm_err,
    input  logic        frm_addr_hit,
    input  logic        frm_bcast,
    input  logic        ovr_evt,
    input  logic        exc_evt,
    input  logic        nak_evt,
    input  logic        busy_evt,
    input  logic [15:0] diag_set,
    input  logic        req_valid,
    input  logic [15:0] req_sub,
    input  logic [15:0] req_data,
    output logic        rsp_valid,
    output logic [1:0]  rsp_kind,
    output logic [15:0] rsp_data,
    output logic [7:0]  rsp_err,
    output logic        listen_only
);
    logic [NCNT-1:0]       inc_vec;
    logic [NCNT-1:0]       clr_vec;
    logic [NCNT*CNT_W-1:0] cnt_flat;
    logic [CNT_W-1:0]      diag_q;
    rsp_kind_e             dec_kind;
    logic [CNT_W-1:0]      dec_data;
    logic [7:0]            dec_err;
    logic                  clr_diag;
    logic                  set_lo;
    logic                  clr_lo;

    diag_event_map u_evt (
        .frm_done     (frm_done),
        .frm_err      (frm_err),
        .frm_addr_hit (frm_addr_hit),
        .frm_bcast    (frm_bcast),
        .ovr_evt      (ovr_evt),
        .exc_evt      (exc_evt),
        .nak_evt      (nak_evt),
        .busy_evt     (busy_evt),
        .inc_vec      (inc_vec)
    );

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        diag_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[i]),
            .clr   (clr_vec[i]),
            .q     (cnt_flat[i*CNT_W +: CNT_W])
        );
    end

    diag_req_decode #(.W(CNT_W)) u_dec (
        .req_valid (req_valid),
        .req_sub   (req_sub),
        .req_data  (req_data),
        .lo_mode   (listen_only),
        .cnt_flat  (cnt_flat),
        .diag_reg  (diag_q),
        .kind      (dec_kind),
        .rdata     (dec_data),
        .err       (dec_err),
        .clr_vec   (clr_vec),
        .clr_diag  (clr_diag),
        .set_lo    (set_lo),
        .clr_lo    (clr_lo)
    );

    // Diagnostic register: sticky bit set, whole-word clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        diag_q <= '0;
        else if (clr_diag) diag_q <= '0;
        else               diag_q <= diag_q | diag_set[CNT_W-1:0];
    end

    // Listen-only flag: entered by subfunction 4, left by restart.
    always_ff @(posedge clk) begin
        if (!rst_n)      listen_only <= 1'b0;
        else if (clr_lo) listen_only <= 1'b0;
        else if (set_lo) listen_only <= 1'b1;
    end

    // Response register: one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= RSP_NONE;
            rsp_data  <= '0;
            rsp_err   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_kind  <= dec_kind;
            rsp_data  <= dec_data;
            rsp_err   <= dec_err;
        end
    end

    // R5
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R5
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R10
    listen_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !listen_only && req_sub == 16'd4 && req_data == 16'd0)
        |=> (listen_only && rsp_kind == RSP_NONE));

    // R9
    restart_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sub == 16'd1 && req_data == 16'hFF00) |=> !listen_only);

    // R12
    err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RSP_ERR) |-> (rsp_err == 8'd1 || rsp_err == 8'd3));
endmodule

// File: tb/sim_diag_counter_bank.sv
// Self-checking bench for diag_counter_bank: a reference model of the
// requirements, seeded random traffic and directed corner cases.
module sim_diag_counter_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frm_done, frm_err, frm_addr_hit, frm_bcast;
    logic        ovr_evt, exc_evt, nak_evt, busy_evt;
    logic [15:0] diag_set;
    logic        req_valid;
    logic [15:0] req_sub, req_data;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [15:0] rsp_data;
    logic [7:0]  rsp_err;
    logic        listen_only;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [15:0] m_cnt [8];
    logic [15:0] m_diag;
    logic        m_lo;

    always #2.5 clk = ~clk;

    diag_counter_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .frm_done(frm_done), .frm_err(frm_err),
        .frm_addr_hit(frm_addr_hit), .frm_bcast(frm_bcast),
        .ovr_evt(ovr_evt), .exc_evt(exc_evt), .nak_evt(nak_evt), .busy_evt(busy_evt),
        .diag_set(diag_set),
        .req_valid(req_valid), .req_sub(req_sub), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
        .rsp_err(rsp_err), .listen_only(listen_only)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string cnt_tag(input int ix);
        if (ix <= 1) return "R2";
        if (ix == 3 || ix == 4) return "R3";
        return "R4";
    endfunction

    // One clock cycle: drive at the falling edge, update the model, check after.
    task automatic cyc(input bit fd, fe, fh, fb, ov, ex, nk, bz,
                       input logic [15:0] ds,
                       input bit rv, input logic [15:0] sb, input logic [15:0] dt);
        int          ek;
        logic [15:0] ed;
        logic [7:0]  ee;
        string       tg;
        bit [7:0]    clr;
        bit          cdiag, slo, clo;
        bit [7:0]    inc;
        logic [7:0]  lo8;
        ek = 0; ed = dt; ee = 0; tg = "R12"; clr = 0; cdiag = 0; slo = 0; clo = 0;
        lo8 = sb[7:0];
        frm_done = fd; frm_err = fe; frm_addr_hit = fh; frm_bcast = fb;
        ovr_evt = ov; exc_evt = ex; nak_evt = nk; busy_evt = bz; diag_set = ds;
        req_valid = rv; req_sub = sb; req_data = dt;
        // expected response from pre-edge model state
        if (rv) begin
            if (m_lo && !(sb == 16'd1)) begin ek = 2; tg = "R11"; end
            else if (sb[15:8] != 0) begin ek = 1; ee = 1; end
            else if (lo8 == 0) begin ek = 0; end
            else if (lo8 == 1) begin
                tg = "R9";
                if (dt == 0 || dt == 16'hFF00) begin clr = 8'b1001_1111; clo = 1; end
                else begin ek = 1; ee = 3; end
            end
            else if (!(lo8 == 2 || lo8 == 4 || lo8 == 10 || lo8 == 20 ||
                       (lo8 >= 11 && lo8 <= 18))) begin ek = 1; ee = 1; end
            else if (dt != 0) begin ek = 1; ee = 3; end
            else if (lo8 == 2) begin ed = m_diag; tg = "R8"; end
            else if (lo8 == 4) begin ek = 2; slo = 1; tg = "R10"; end
            else if (lo8 == 10) begin clr = 8'hFF; cdiag = 1; tg = "R6"; end
            else if (lo8 == 20) begin clr = 8'h80; tg = "R7"; end
            else begin ed = m_cnt[lo8 - 11]; tg = cnt_tag(lo8 - 11); end
        end
        // model next state
        inc = 0;
        inc[0] = fd && !fe;
        inc[1] = fd && fe;
        inc[3] = fd && !fe && fh;
        inc[4] = fd && !fe && fh && fb;
        inc[2] = ex; inc[5] = nk; inc[6] = bz; inc[7] = ov;
        for (int i = 0; i < 8; i++) begin
            if (clr[i]) m_cnt[i] = 16'd0;
            else if (inc[i]) m_cnt[i] = m_cnt[i] + 16'd1;
        end
        m_diag = cdiag ? 16'd0 : (m_diag | ds);
        if (clo) m_lo = 0; else if (slo) m_lo = 1;
        @(negedge clk);
        check(rsp_valid == rv, "R5", "rsp_valid", rsp_valid, rv);
        if (rv) begin
            check(rsp_kind == ek[1:0], tg, "rsp_kind", rsp_kind, ek);
            if (ek == 0) check(rsp_data == ed, tg, "rsp_data", rsp_data, ed);
            if (ek == 1) check(rsp_err == ee, tg, "rsp_err", rsp_err, ee);
        end
        check(listen_only == m_lo, "R10", "listen_only", listen_only, m_lo);
    endtask

    task automatic idle();
        cyc(0,0,0,0,0,0,0,0, 16'd0, 0, 16'd0, 16'd0);
    endtask

    task automatic req(input logic [15:0] sb, input logic [15:0] dt);
        cyc(0,0,0,0,0,0,0,0, 16'd0, 1, sb, dt);
    endtask

    task automatic read_all();
        for (int i = 11; i <= 18; i++) req(16'(i), 16'd0);
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0;
        frm_done = 0; frm_err = 0; frm_addr_hit = 0; frm_bcast = 0;
        ovr_evt = 0; exc_evt = 0; nak_evt = 0; busy_evt = 0; diag_set = 0;
        req_valid = 0; req_sub = 0; req_data = 0;
        for (int i = 0; i < 8; i++) m_cnt[i] = 16'd0;
        m_diag = 0; m_lo = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(listen_only == 0, "R1", "listen_only after reset", listen_only, 0);
        rst_n = 1;
        read_all();
        req(16'd2, 16'd0);

        // R2, R3: frame outcomes
        cyc(1,0,0,0,0,0,0,0, 16'd0, 0, 0, 0);
        cyc(1,1,1,1,0,0,0,0, 16'd0, 0, 0, 0);
        cyc(1,0,1,0,0,0,0,0, 16'd0, 0, 0, 0);
        cyc(1,0,1,1,0,0,0,0, 16'd0, 0, 0, 0);
        // R4: each event pulse
        cyc(0,0,0,0,1,1,1,1, 16'h0005, 0, 0, 0);
        read_all();
        // R8: diagnostic register sticky bits
        cyc(0,0,0,0,0,0,0,0, 16'h8100, 1, 16'd2, 16'd0);
        req(16'd2, 16'd0);
        // R12: error precedence
        req(16'h0100, 16'd0);
        req(16'd3, 16'd0);
        req(16'd11, 16'd5);
        req(16'h010B, 16'd5);
        req(16'd0, 16'hBEEF);
        // R6: clear wins over same-cycle increment
        cyc(1,0,1,0,1,1,1,1, 16'h0001, 1, 16'd10, 16'd0);
        read_all();
        req(16'd2, 16'd0);
        // R10, R11: listen-only, ignored requests
        cyc(0,0,0,0,1,0,1,0, 16'd0, 0, 0, 0);
        req(16'd4, 16'd0);
        req(16'd10, 16'd0);
        req(16'd11, 16'd0);
        cyc(1,0,1,0,0,0,0,0, 16'd0, 0, 0, 0);
        // R9: bad restart data, then good restart keeps NAK and busy
        req(16'd1, 16'h1234);
        cyc(0,0,0,0,0,0,0,1, 16'd0, 0, 0, 0);
        req(16'd1, 16'hFF00);
        read_all();
        // R7: overrun-only clear
        cyc(1,0,0,0,1,0,0,0, 16'd0, 1, 16'd20, 16'd0);
        cyc(0,0,0,0,1,1,0,0, 16'd0, 0, 0, 0);
        req(16'd20, 16'd0);
        read_all();

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            bit rv;
            logic [15:0] sb, dt;
            int pick;
            rv = ($urandom % 2) == 0;
            pick = $urandom % 16;
            case (pick)
                0: sb = 16'd0;   1: sb = 16'd1;   2: sb = 16'd2;
                3: sb = 16'd4;   4: sb = 16'd10;  5: sb = 16'd20;
                6: sb = 16'd3;   7: sb = 16'h0105;
                default: sb = 16'(11 + ($urandom % 8));
            endcase
            case ($urandom % 8)
                0: dt = 16'hFF00;
                1: dt = 16'($urandom);
                default: dt = 16'd0;
            endcase
            cyc(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 2) == 0,
                ($urandom % 3) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0,
                ($urandom % 6) == 0, ($urandom % 6) == 0,
                (($urandom % 8) == 0) ? 16'(1 << ($urandom % 16)) : 16'd0,
                rv, sb, dt);
        end
        req(16'd1, 16'd0);
        read_all();

        // R4: wrap-around of the overrun counter
        req(16'd20, 16'd0);
        for (int n = 0; n < 65535; n++) cyc(0,0,0,0,1,0,0,0, 16'd0, 0, 0, 0);
        req(16'd18, 16'd0);
        cyc(0,0,0,0,1,0,0,0, 16'd0, 0, 0, 0);
        req(16'd18, 16'd0);
        idle();

        done = 1;
        report();
    end
endmodule